// File: doc/BRIEF.md
# Mailbox Interrupt Router

This block turns mailbox-write events into interrupt requests. A strobe for mailbox k sets two pending bits on the next clock: one for the local interrupt path and one for the bus interrupt path. Each pending bit stays set until software writes a one to it. The pending bits are routed through two mapping registers. Each mapping register holds one 3-bit field for each mailbox. The local field picks one of eight local interrupt lines. The bus field picks one of seven bus interrupt levels, or no level at all.

Software reaches the four registers through a simple port. A write takes effect on the clock edge where the write enable is high. Read data is combinational from the address. The outputs are combinational from the registered state, so each output follows the pending bits routed to it, starting in the cycle after the strobe.

Top module: `mbox_irq_router`

## Requirements
- R1: After reset, both mapping registers read 0, both status registers read 0, and every local and bus interrupt output is low.
- R2: The local mapping register is at offset 0x340. Mailbox k's field is bits [4k+2:4k]. A field value n drives local_irq_o[n] while the mailbox's local status bit is set. Bits 4k+3 and bits above 15 read as 0, whatever was written.
- R3: The bus mapping register is at offset 0x344, with the same field layout and reserved bits as R2. A field value c in 1..7 drives bus level c, which is bus_irq_o[c-1], while the mailbox's bus status bit is set. The bus outputs are all low while every bus status bit is clear.
- R4: A high on mbox_wr_stb[k] at a clock edge sets bit k of the local status register (offset 0x304) and bit k of the bus status register (offset 0x314) at that edge. A status bit reads 1 while active. Status register bits above 3 read 0.
- R5: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A write to one status register does not change the other status register.
- R6: If a strobe and a write-one-clear reach the same status bit at the same edge, the bit ends up set.
- R7: Each output is the OR of all active status bits routed to it. It stays high until every source routed to it has been cleared.
- R8: A bus field value of 0 raises no bus output, but the bus status bit is still set.
- R9: Any other address reads 0, and writing to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr_en | input | 1 | Register write enable |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr |
| mbox_wr_stb | input | 4 | One strobe per mailbox; high marks a mailbox write |
| local_irq_o | output | 8 | Local interrupt lines 0..7 |
| bus_irq_o | output | 7 | Bus interrupt levels 1..7 (bit i is level i+1) |

## Verification
A table of mapping pairs and strobe sets exercises the routing. The table covers these cases:
- every mailbox on line 0;
- every mailbox on a distinct line and level;
- all mailboxes sharing one line and the top level;
- a mix with unrouted bus fields;
- all-ones writes that show the reserved bits reading as zero.

These cases tell apart field-offset errors, wrong level numbering and missing OR fan-in. Directed tests then separate the following:
- a clear of one bit from a clear of the whole register;
- a clear of the local path from a clear of the bus path;
- a write of zero from a clear;
- set-wins from clear-wins when both reach the same bit at the same edge.

Further directed tests check that a shared output stays high until its last source is cleared, and that unknown addresses neither read back nor store data.

// File: rtl/mbox_irq_pkg.sv
package mbox_irq_pkg;
    localparam int MBOX_N  = 4;
    localparam int FLD_W   = 3;
    localparam int SLOT_W  = FLD_W + 1;
    localparam int DATA_W  = MBOX_N * SLOT_W;
    localparam int ADDR_W  = 12;
    localparam int LOC_N   = 1 << FLD_W;
    localparam int BUS_N   = (1 << FLD_W) - 1;

    localparam logic [ADDR_W-1:0] OFS_LMAP = 12'h340;
    localparam logic [ADDR_W-1:0] OFS_BMAP = 12'h344;
    localparam logic [ADDR_W-1:0] OFS_LST  = 12'h304;
    localparam logic [ADDR_W-1:0] OFS_BST  = 12'h314;

    typedef logic [MBOX_N-1:0][FLD_W-1:0] map_t;

    typedef struct packed {
        map_t              lmap;
        map_t              bmap;
        logic [MBOX_N-1:0] lst;
        logic [MBOX_N-1:0] bst;
    } rtr_state_t;
endpackage

// File: rtl/mbox_irq_regs.sv
module mbox_irq_regs
    import mbox_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [MBOX_N-1:0] stb,
    output map_t              lmap_o,
    output map_t              bmap_o,
    output logic [MBOX_N-1:0] lst_o,
    output logic [MBOX_N-1:0] bst_o
);
    rtr_state_t st_d, st_q;
    logic [MBOX_N-1:0] lclr, bclr;
    logic unused_wdata;

    assign unused_wdata = ^wdata;

    always_comb begin
        st_d = st_q;
        lclr = '0;
        bclr = '0;
        if (wr_en && addr == OFS_LMAP) begin
            for (int k = 0; k < MBOX_N; k++) st_d.lmap[k] = wdata[k*SLOT_W +: FLD_W];
        end
        if (wr_en && addr == OFS_BMAP) begin
            for (int k = 0; k < MBOX_N; k++) st_d.bmap[k] = wdata[k*SLOT_W +: FLD_W];
        end
        if (wr_en && addr == OFS_LST) lclr = wdata[MBOX_N-1:0];
        if (wr_en && addr == OFS_BST) bclr = wdata[MBOX_N-1:0];
        // set has priority over clear
        st_d.lst = (st_q.lst & ~lclr) | stb;
        st_d.bst = (st_q.bst & ~bclr) | stb;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lmap_o = st_q.lmap;
    assign bmap_o = st_q.bmap;
    assign lst_o  = st_q.lst;
    assign bst_o  = st_q.bst;
endmodule

// File: rtl/mbox_irq_route.sv
module mbox_irq_route
    import mbox_irq_pkg::*;
(
    input  map_t              lmap,
    input  map_t              bmap,
    input  logic [MBOX_N-1:0] lst,
    input  logic [MBOX_N-1:0] bst,
    output logic [LOC_N-1:0]  local_irq,
    output logic [BUS_N-1:0]  bus_irq
);
    for (genvar j = 0; j < LOC_N; j++) begin : g_loc
        logic [MBOX_N-1:0] hit;
        for (genvar k = 0; k < MBOX_N; k++) begin : g_src
            assign hit[k] = lst[k] && (lmap[k] == FLD_W'(j));
        end
        assign local_irq[j] = |hit;
    end

    for (genvar j = 0; j < BUS_N; j++) begin : g_bus
        logic [MBOX_N-1:0] hit;
        for (genvar k = 0; k < MBOX_N; k++) begin : g_src
            assign hit[k] = bst[k] && (bmap[k] == FLD_W'(j + 1));
        end
        assign bus_irq[j] = |hit;
    end
endmodule

// File: rtl/mbox_irq_rdmux.sv
module mbox_irq_rdmux
    import mbox_irq_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  map_t              lmap,
    input  map_t              bmap,
    input  logic [MBOX_N-1:0] lst,
    input  logic [MBOX_N-1:0] bst,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] lmap_w, bmap_w;

    always_comb begin
        lmap_w = '0;
        bmap_w = '0;
        for (int k = 0; k < MBOX_N; k++) begin
            lmap_w[k*SLOT_W +: FLD_W] = lmap[k];
            bmap_w[k*SLOT_W +: FLD_W] = bmap[k];
        end
        case (addr)
            OFS_LMAP: rdata = lmap_w;
            OFS_BMAP: rdata = bmap_w;
            OFS_LST:  rdata = DATA_W'(lst);
            OFS_BST:  rdata = DATA_W'(bst);
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/mbox_irq_router.sv
module mbox_irq_router
    import mbox_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [MBOX_N-1:0] mbox_wr_stb,
    output logic [LOC_N-1:0]  local_irq_o,
    output logic [BUS_N-1:0]  bus_irq_o
);
    map_t              lmap_w, bmap_w;
    logic [MBOX_N-1:0] lst_w, bst_w;

    mbox_irq_regs regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
        .wdata(reg_wdata), .stb(mbox_wr_stb),
        .lmap_o(lmap_w), .bmap_o(bmap_w), .lst_o(lst_w), .bst_o(bst_w)
    );

    mbox_irq_route route_i (
        .lmap(lmap_w), .bmap(bmap_w), .lst(lst_w), .bst(bst_w),
        .local_irq(local_irq_o), .bus_irq(bus_irq_o)
    );

    mbox_irq_rdmux rdmux_i (
        .addr(reg_addr), .lmap(lmap_w), .bmap(bmap_w),
        .lst(lst_w), .bst(bst_w), .rdata(reg_rdata)
    );
endmodule

// File: rtl/mbox_irq_chk.sv
module mbox_irq_chk
    import mbox_irq_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [MBOX_N-1:0] mbox_wr_stb,
    input logic [LOC_N-1:0]  local_irq_o,
    input logic [BUS_N-1:0]  bus_irq_o,
    input map_t              bmap,
    input logic [MBOX_N-1:0] lst,
    input logic [MBOX_N-1:0] bst
);
    // R4 / R6: a strobe always leaves the bit set, even against a clear
    a_r4_local_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_wr_stb != '0) |=> ((lst & $past(mbox_wr_stb)) == $past(mbox_wr_stb)));
    a_r6_bus_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mbox_wr_stb != '0) |=> ((bst & $past(mbox_wr_stb)) == $past(mbox_wr_stb)));
    // R5: written ones clear the bit unless a strobe arrived
    a_r5_local_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_LST) |=>
        ((lst & $past(reg_wdata[MBOX_N-1:0]) & ~$past(mbox_wr_stb)) == '0));
    a_r5_bus_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_en && reg_addr == OFS_BST) |=>
        ((bst & $past(reg_wdata[MBOX_N-1:0]) & ~$past(mbox_wr_stb)) == '0));
    // R7: no more active lines than active sources
    a_r7_fanin: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(local_irq_o) <= $countones(lst));
    // R3: no bus output without pending bus status
    a_r3_bus_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (bst == '0) |-> (bus_irq_o == '0));
    // R8: all-unrouted bus fields keep bus outputs low
    a_r8_unrouted: assert property (@(posedge clk) disable iff (!rst_n)
        (bmap == '0) |-> (bus_irq_o == '0));
endmodule

bind mbox_irq_router mbox_irq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .mbox_wr_stb(mbox_wr_stb), .local_irq_o(local_irq_o),
    .bus_irq_o(bus_irq_o), .bmap(bmap_w), .lst(lst_w), .bst(bst_w)
);

// File: tb/mbox_irq_router_tb_top.sv
module mbox_irq_router_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [3:0]  mbox_wr_stb = '0;
    logic [7:0]  local_irq_o;
    logic [6:0]  bus_irq_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbox_irq_router dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mbox_wr_stb(mbox_wr_stb),
        .local_irq_o(local_irq_o), .bus_irq_o(bus_irq_o)
    );

    // {lmap, bmap, strobes, expected local, expected bus}
    localparam logic [50:0] VEC [6] = '{
        {16'h0000, 16'h0000, 4'b0001, 8'h01, 7'h00},
        {16'h7531, 16'h4321, 4'b1111, 8'hAA, 7'h0F},
        {16'h7531, 16'h4321, 4'b0100, 8'h20, 7'h04},
        {16'h2222, 16'h7777, 4'b1010, 8'h04, 7'h40},
        {16'h0643, 16'h5060, 4'b1001, 8'h09, 7'h10},
        {16'hFFFF, 16'hFFFF, 4'b0001, 8'h80, 7'h40}
    };

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [15:0] d, input logic [3:0] s);
        @(negedge clk);
        reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d; mbox_wr_stb = s;
        @(negedge clk);
        reg_wr_en = 1'b0; mbox_wr_stb = '0;
    endtask

    task automatic stb(input logic [3:0] s);
        @(negedge clk);
        mbox_wr_stb = s;
        @(negedge clk);
        mbox_wr_stb = '0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual expired expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] d;
        repeat (3) @(negedge clk);
        // R1 reset state
        rd(12'h340, d); chk("R1 lmap", d, 16'h0);
        rd(12'h344, d); chk("R1 bmap", d, 16'h0);
        rd(12'h304, d); chk("R1 lst", d, 16'h0);
        rd(12'h314, d); chk("R1 bst", d, 16'h0);
        chk("R1 irq", {1'b0, bus_irq_o, local_irq_o}, 16'h0);
        @(negedge clk); rst_n = 1'b1;

        // R2 R3 R4 R7 table walk
        for (int i = 0; i < 6; i++) begin
            logic [50:0] v;
            v = VEC[i];
            wr(12'h340, v[50:35], 4'b0);
            wr(12'h344, v[34:19], 4'b0);
            rd(12'h340, d); chk("R2 lmap readback", d, v[50:35] & 16'h7777);
            rd(12'h344, d); chk("R3 bmap readback", d, v[34:19] & 16'h7777);
            stb(v[18:15]);
            chk("R2 R7 local", {8'h0, local_irq_o}, {8'h0, v[14:7]});
            chk("R3 R7 bus", {9'h0, bus_irq_o}, {9'h0, v[6:0]});
            rd(12'h304, d); chk("R4 lst", d, {12'h0, v[18:15]});
            rd(12'h314, d); chk("R4 bst", d, {12'h0, v[18:15]});
            wr(12'h304, 16'hFFFF, 4'b0);
            wr(12'h314, 16'hFFFF, 4'b0);
            chk("R5 cleared", {1'b0, bus_irq_o, local_irq_o}, 16'h0);
        end

        // R5: partial clear, path independence, zero write
        wr(12'h340, 16'h0010, 4'b0);   // mb0 line0, mb1 line1
        wr(12'h344, 16'h0021, 4'b0);   // mb0 level1, mb1 level2
        stb(4'b0011);
        wr(12'h304, 16'h0001, 4'b0);
        rd(12'h304, d); chk("R5 partial lst", d, 16'h0002);
        rd(12'h314, d); chk("R5 other path kept", d, 16'h0003);
        chk("R5 local out", {8'h0, local_irq_o}, 16'h0002);
        chk("R5 bus out", {9'h0, bus_irq_o}, 16'h0003);
        wr(12'h314, 16'h0000, 4'b0);
        rd(12'h314, d); chk("R5 zero write", d, 16'h0003);
        wr(12'h304, 16'h000F, 4'b0);
        wr(12'h314, 16'h000F, 4'b0);

        // R6: set wins over same-cycle clear
        wr(12'h304, 16'h0004, 4'b0100);
        rd(12'h304, d); chk("R6 set wins", d, 16'h0004);
        rd(12'h314, d); chk("R6 bus set", d, 16'h0004);
        wr(12'h304, 16'h000F, 4'b0);
        wr(12'h314, 16'h000F, 4'b0);

        // R7: shared line held until last source clears
        wr(12'h340, 16'h0550, 4'b0);   // mb1, mb2 on line 5
        stb(4'b0110);
        wr(12'h304, 16'h0002, 4'b0);
        chk("R7 still high", {8'h0, local_irq_o}, 16'h0020);
        wr(12'h304, 16'h0004, 4'b0);
        chk("R7 low", {8'h0, local_irq_o}, 16'h0000);

        // R8: unrouted bus field
        wr(12'h344, 16'h0000, 4'b0);
        wr(12'h314, 16'h000F, 4'b0);
        stb(4'b1000);
        rd(12'h314, d); chk("R8 status set", d, 16'h0008);
        chk("R8 no bus out", {9'h0, bus_irq_o}, 16'h0);

        // R9: unknown address
        wr(12'h300, 16'hFFFF, 4'b0);
        rd(12'h300, d); chk("R9 read zero", d, 16'h0);
        rd(12'h340, d); chk("R9 lmap kept", d, 16'h0550);
        rd(12'h344, d); chk("R9 bmap kept", d, 16'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule